// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block is the per-processor end of a two-level interrupt system. It holds at most one pending external interrupt and drives one processor interrupt line. A source unit offers interrupts to it as a source number plus an 8-bit priority. The controller either takes each offer or bounces it back. It also returns end-of-interrupt notices and resend requests to the source side.

Software sees four register operations:
- set the current processor priority;
- set the priority of the built-in inter-processor interrupt (IPI);
- read and acknowledge the pending interrupt through a 32-bit acknowledge word;
- write end-of-interrupt.

A numerically smaller priority is more favoured. Whenever a better interrupt displaces a pending one, the displaced source is handed back to the source unit so that it can be offered again later.

Top module: `irq_present_ctl`

## Requirements
- R1: After reset the acknowledge word reads 0, the interrupt line is low, and no reject, EOI or resend strobe is active. Internally the pending priority and the IPI priority both start at 0xFF.
- R2: The acknowledge word carries the current processor priority in bits 31:24 and the pending source number in bits 23:0. A source field of 0 means nothing is pending, and the interrupt line is never high while the source field is 0.
- R3: An offer is refused when its priority is greater than or equal to the current priority, or when a pending interrupt's priority is less than or equal to the offered one. A refused offer shows up on the reject strobe with its own source one cycle later, and the acknowledge word stays unchanged.
- R4: An offer that is not refused replaces the pending interrupt one cycle later and raises the interrupt line. If another source was pending, that source appears on the reject strobe in the same cycle.
- R5: An acknowledge read returns the whole acknowledge word in the cycle of the read. One cycle later the line is low, the source field is 0, and the priority byte holds the priority of the interrupt just taken.
- R6: An end-of-interrupt write loads bits 31:24 of the written word as the current priority. It pulses the EOI strobe with bits 23:0 of the word. If nothing is pending, it also performs a resend.
- R7: Writing a current priority lower than the present one, while a source is pending whose priority is greater than or equal to the new value, clears the pending source, drops the line and rejects that source. If the pending priority is lower than the new value, the pending source is kept.
- R8: Writing a current priority equal to or higher than the present one while nothing is pending performs a resend. The resend strobe follows only an end-of-interrupt write or a current-priority write.
- R9: Writing an IPI priority below the current priority presents the IPI source at that priority, unless the pending interrupt's priority is already less than or equal to it. Any source displaced this way is rejected. A value at or above the current priority changes nothing visible.
- R10: A resend first presents the IPI, if the IPI priority is below the new current priority, and pulses the resend strobe in the same cycle.
- R11: If several operations are strobed in one cycle, only one takes effect, chosen in this order: end-of-interrupt, current-priority write, IPI write, acknowledge, offer. An offer with source number 0 is ignored.
- R12: The IPI source number is the parameter IPI_SRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Offer from the source unit this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| cur_prio_wr | input | 1 | Current-priority write strobe |
| cur_prio_wdata | input | 8 | New current priority |
| ipi_prio_wr | input | 1 | IPI priority write strobe |
| ipi_prio_wdata | input | 8 | New IPI priority |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_rdata | output | 32 | Acknowledge word (priority and source) |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_wdata | input | 32 | End-of-interrupt word |
| irq_out | output | 1 | Processor interrupt line |
| rej_valid | output | 1 | Reject strobe to source unit |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | EOI strobe to source unit |
| eoi_src | output | 24 | Source number that has ended |
| resend_req | output | 1 | Resend request to source unit |

## Verification
The bench builds the block with IPI_SRC set to 5 rather than its default of 2. This shows that the IPI number comes from the parameter, and it keeps IPI traffic distinct from the small offer numbers. Widths stay at their defaults, so every priority byte and every 24-bit source value can be driven directly. This covers the boundaries where an offer's priority equals the current or the pending priority. A directed sequence walks through displacement, acknowledge, end-of-interrupt with resend, and IPI re-presentation. A seeded stretch of mixed and simultaneous strobes then exercises the precedence order.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    // One operation is carried out per cycle; the order of the enum is not used for precedence.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_EOI,
        OP_CUR,
        OP_IPI,
        OP_ACK,
        OP_OFFER
    } ipc_op_e;
endpackage

// File: rtl/ipc_op_select.sv
module ipc_op_select
    import ipc_pkg::*;
#(
    parameter int SRC_W = 24
) (
    input  logic             eoi_wr,
    input  logic             cur_prio_wr,
    input  logic             ipi_prio_wr,
    input  logic             ack_rd,
    input  logic             offer_valid,
    input  logic [SRC_W-1:0] offer_src,
    output ipc_op_e          op
);
    always_comb begin
        if (eoi_wr)                              op = OP_EOI;
        else if (cur_prio_wr)                    op = OP_CUR;
        else if (ipi_prio_wr)                    op = OP_IPI;
        else if (ack_rd)                         op = OP_ACK;
        else if (offer_valid && offer_src != '0) op = OP_OFFER;
        else                                     op = OP_IDLE;
    end
endmodule

// File: rtl/ipc_prio_judge.sv
// Decides whether a candidate at cand_prio takes the presentation slot.
module ipc_prio_judge #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [SRC_W-1:0]  pend_src,
    input  logic [PRIO_W-1:0] pend_prio,
    output logic              win,
    output logic              displace
);
    logic busy_better;
    always_comb begin
        busy_better = (pend_src != '0) && (pend_prio <= cand_prio);
        win         = (cand_prio < cur_prio) && !busy_better;
        displace    = win && (pend_src != '0);
    end
endmodule

// File: rtl/irq_present_ctl.sv
module irq_present_ctl
    import ipc_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    offer_valid,
    input  logic [SRC_W-1:0]        offer_src,
    input  logic [PRIO_W-1:0]       offer_prio,
    input  logic                    cur_prio_wr,
    input  logic [PRIO_W-1:0]       cur_prio_wdata,
    input  logic                    ipi_prio_wr,
    input  logic [PRIO_W-1:0]       ipi_prio_wdata,
    input  logic                    ack_rd,
    output logic [PRIO_W+SRC_W-1:0] ack_rdata,
    input  logic                    eoi_wr,
    input  logic [PRIO_W+SRC_W-1:0] eoi_wdata,
    output logic                    irq_out,
    output logic                    rej_valid,
    output logic [SRC_W-1:0]        rej_src,
    output logic                    eoi_valid,
    output logic [SRC_W-1:0]        eoi_src,
    output logic                    resend_req
);
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_OFF = '1;
    localparam logic [SRC_W-1:0]  IPI_ID   = SRC_W'(IPI_SRC);

    typedef struct packed {
        logic [PRIO_W-1:0] cur_prio;
        logic [SRC_W-1:0]  pend_src;
        logic [PRIO_W-1:0] pend_prio;
        logic [PRIO_W-1:0] ipi_prio;
        logic              irq;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_src;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_src;
        logic              resend;
    } ipc_state_t;

    ipc_state_t st_q, st_d;
    ipc_op_e    op;

    ipc_op_select #(.SRC_W(SRC_W)) sel_i (
        .eoi_wr      (eoi_wr),
        .cur_prio_wr (cur_prio_wr),
        .ipi_prio_wr (ipi_prio_wr),
        .ack_rd      (ack_rd),
        .offer_valid (offer_valid),
        .offer_src   (offer_src),
        .op          (op)
    );

    // Offer path
    logic offer_win, offer_disp;
    ipc_prio_judge #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) offer_judge_i (
        .cand_prio (offer_prio),
        .cur_prio  (st_q.cur_prio),
        .pend_src  (st_q.pend_src),
        .pend_prio (st_q.pend_prio),
        .win       (offer_win),
        .displace  (offer_disp)
    );

    // IPI priority write path
    logic ipiw_win, ipiw_disp;
    ipc_prio_judge #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) ipi_wr_judge_i (
        .cand_prio (ipi_prio_wdata),
        .cur_prio  (st_q.cur_prio),
        .pend_src  (st_q.pend_src),
        .pend_prio (st_q.pend_prio),
        .win       (ipiw_win),
        .displace  (ipiw_disp)
    );

    // Resend path: runs only with nothing pending, against the new current priority
    logic [PRIO_W-1:0] resend_cur;
    logic              rs_win, rs_disp;
    assign resend_cur = (op == OP_EOI) ? eoi_wdata[WORD_W-1 -: PRIO_W] : cur_prio_wdata;
    ipc_prio_judge #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) resend_judge_i (
        .cand_prio (st_q.ipi_prio),
        .cur_prio  (resend_cur),
        .pend_src  ('0),
        .pend_prio (PRIO_OFF),
        .win       (rs_win),
        .displace  (rs_disp)
    );

    logic do_resend;

    always_comb begin
        st_d         = st_q;
        st_d.rej_v   = 1'b0;
        st_d.rej_src = '0;
        st_d.eoi_v   = 1'b0;
        st_d.eoi_src = '0;
        st_d.resend  = 1'b0;
        do_resend    = 1'b0;

        unique case (op)
            OP_EOI: begin
                st_d.cur_prio = eoi_wdata[WORD_W-1 -: PRIO_W];
                st_d.eoi_v    = 1'b1;
                st_d.eoi_src  = eoi_wdata[SRC_W-1:0];
                do_resend     = (st_q.pend_src == '0);
            end
            OP_CUR: begin
                st_d.cur_prio = cur_prio_wdata;
                if (cur_prio_wdata < st_q.cur_prio) begin
                    if (st_q.pend_src != '0 && cur_prio_wdata <= st_q.pend_prio) begin
                        st_d.pend_src = '0;
                        st_d.irq      = 1'b0;
                        st_d.rej_v    = 1'b1;
                        st_d.rej_src  = st_q.pend_src;
                    end
                end else begin
                    do_resend = (st_q.pend_src == '0);
                end
            end
            OP_IPI: begin
                st_d.ipi_prio = ipi_prio_wdata;
                if (ipiw_win) begin
                    if (ipiw_disp) begin
                        st_d.rej_v   = 1'b1;
                        st_d.rej_src = st_q.pend_src;
                    end
                    st_d.pend_src  = IPI_ID;
                    st_d.pend_prio = ipi_prio_wdata;
                    st_d.irq       = 1'b1;
                end
            end
            OP_ACK: begin
                st_d.cur_prio = st_q.pend_prio;
                st_d.pend_src = '0;
                st_d.irq      = 1'b0;
            end
            OP_OFFER: begin
                if (offer_win) begin
                    if (offer_disp) begin
                        st_d.rej_v   = 1'b1;
                        st_d.rej_src = st_q.pend_src;
                    end
                    st_d.pend_src  = offer_src;
                    st_d.pend_prio = offer_prio;
                    st_d.irq       = 1'b1;
                end else begin
                    st_d.rej_v   = 1'b1;
                    st_d.rej_src = offer_src;
                end
            end
            default: ;
        endcase

        if (do_resend) begin
            if (rs_win && !rs_disp) begin
                st_d.pend_src  = IPI_ID;
                st_d.pend_prio = st_q.ipi_prio;
                st_d.irq       = 1'b1;
            end
            st_d.resend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.pend_prio <= PRIO_OFF;
            st_q.ipi_prio  <= PRIO_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_rdata  = {st_q.cur_prio, st_q.pend_src};
    assign irq_out    = st_q.irq;
    assign rej_valid  = st_q.rej_v;
    assign rej_src    = st_q.rej_src;
    assign eoi_valid  = st_q.eoi_v;
    assign eoi_src    = st_q.eoi_src;
    assign resend_req = st_q.resend;
endmodule

// File: rtl/ipc_sva.sv
module ipc_sva #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    offer_valid,
    input logic [SRC_W-1:0]        offer_src,
    input logic [PRIO_W-1:0]       offer_prio,
    input logic                    cur_prio_wr,
    input logic [PRIO_W-1:0]       cur_prio_wdata,
    input logic                    ipi_prio_wr,
    input logic [PRIO_W-1:0]       ipi_prio_wdata,
    input logic                    ack_rd,
    input logic [PRIO_W+SRC_W-1:0] ack_rdata,
    input logic                    eoi_wr,
    input logic [PRIO_W+SRC_W-1:0] eoi_wdata,
    input logic                    irq_out,
    input logic                    rej_valid,
    input logic [SRC_W-1:0]        rej_src,
    input logic                    eoi_valid,
    input logic [SRC_W-1:0]        eoi_src,
    input logic                    resend_req
);
    localparam int WORD_W = PRIO_W + SRC_W;

    logic no_reg_op;
    assign no_reg_op = !eoi_wr && !cur_prio_wr && !ipi_prio_wr;

    assert_line_has_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ack_rdata[SRC_W-1:0] != '0);

    assert_offer_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (no_reg_op && !ack_rd && offer_valid && offer_src != '0
         && offer_prio >= ack_rdata[WORD_W-1 -: PRIO_W])
        |=> rej_valid && rej_src == $past(offer_src) && $stable(ack_rdata));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (no_reg_op && ack_rd) |=> !irq_out && ack_rdata[SRC_W-1:0] == '0);

    assert_eoi_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> eoi_valid && eoi_src == $past(eoi_wdata[SRC_W-1:0])
                   && ack_rdata[WORD_W-1 -: PRIO_W] == $past(eoi_wdata[WORD_W-1 -: PRIO_W]));

    assert_resend_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |-> $past(eoi_wr || cur_prio_wr));

    assert_ipi_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoi_wr && !cur_prio_wr && ipi_prio_wr
         && ipi_prio_wdata >= ack_rdata[WORD_W-1 -: PRIO_W])
        |=> $stable(ack_rdata) && !rej_valid);

    assert_reject_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> rej_src != '0);
endmodule

bind irq_present_ctl ipc_sva #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) sva_i (.*);

// File: tb/irq_present_ctl_tb.sv
`timescale 1ns/1ps
module irq_present_ctl_tb_top;
    localparam int IPI = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 0;
    logic [23:0] offer_src = 0;
    logic [7:0]  offer_prio = 0;
    logic        cur_prio_wr = 0;
    logic [7:0]  cur_prio_wdata = 0;
    logic        ipi_prio_wr = 0;
    logic [7:0]  ipi_prio_wdata = 0;
    logic        ack_rd = 0;
    logic [31:0] ack_rdata;
    logic        eoi_wr = 0;
    logic [31:0] eoi_wdata = 0;
    logic        irq_out, rej_valid, eoi_valid, resend_req;
    logic [23:0] rej_src, eoi_src;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_cur, m_src, m_pend, m_ipi, m_irq, m_rej_v, m_rej_src, m_eoi_v, m_eoi_src, m_resend;

    always #4 clk = ~clk;

    irq_present_ctl #(.IPI_SRC(IPI)) dut_i (.*);

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(ack_rdata == {m_cur[7:0], m_src[23:0]}, tag, "ack_rdata", ack_rdata, {m_cur[7:0], m_src[23:0]});
        chk(irq_out == m_irq[0], tag, "irq_out", irq_out, m_irq);
        chk(rej_valid == m_rej_v[0], tag, "rej_valid", rej_valid, m_rej_v);
        if (m_rej_v != 0) chk(rej_src == m_rej_src[23:0], tag, "rej_src", rej_src, m_rej_src);
        chk(eoi_valid == m_eoi_v[0], tag, "eoi_valid", eoi_valid, m_eoi_v);
        if (m_eoi_v != 0) chk(eoi_src == m_eoi_src[23:0], tag, "eoi_src", eoi_src, m_eoi_src);
        chk(resend_req == m_resend[0], tag, "resend_req", resend_req, m_resend);
    endtask

    // Present a source if it beats the current priority and the pending one.
    function automatic bit better(int p);
        return (p < m_cur) && !(m_src != 0 && m_pend <= p);
    endfunction

    task automatic model_step();
        bit rs = 0;
        m_rej_v = 0; m_eoi_v = 0; m_resend = 0;
        if (eoi_wr) begin
            m_cur = eoi_wdata[31:24];
            m_eoi_v = 1; m_eoi_src = eoi_wdata[23:0];
            rs = (m_src == 0);
        end else if (cur_prio_wr) begin
            if (cur_prio_wdata < m_cur) begin
                if (m_src != 0 && cur_prio_wdata <= m_pend) begin
                    m_rej_v = 1; m_rej_src = m_src; m_src = 0; m_irq = 0;
                end
            end else rs = (m_src == 0);
            m_cur = cur_prio_wdata;
        end else if (ipi_prio_wr) begin
            m_ipi = ipi_prio_wdata;
            if (better(m_ipi)) begin
                if (m_src != 0) begin m_rej_v = 1; m_rej_src = m_src; end
                m_src = IPI; m_pend = m_ipi; m_irq = 1;
            end
        end else if (ack_rd) begin
            m_cur = m_pend; m_src = 0; m_irq = 0;
        end else if (offer_valid && offer_src != 0) begin
            if (better(offer_prio)) begin
                if (m_src != 0) begin m_rej_v = 1; m_rej_src = m_src; end
                m_src = offer_src; m_pend = offer_prio; m_irq = 1;
            end else begin
                m_rej_v = 1; m_rej_src = offer_src;
            end
        end
        if (rs) begin
            if (m_ipi < m_cur) begin m_src = IPI; m_pend = m_ipi; m_irq = 1; end
            m_resend = 1;
        end
    endtask

    task automatic clear_in();
        offer_valid = 0; cur_prio_wr = 0; ipi_prio_wr = 0; ack_rd = 0; eoi_wr = 0;
    endtask

    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        clear_in();
    endtask

    task automatic offer(int s, int p, string tag);
        offer_valid = 1; offer_src = s[23:0]; offer_prio = p[7:0]; cyc(tag);
    endtask
    task automatic wr_cur(int p, string tag);
        cur_prio_wr = 1; cur_prio_wdata = p[7:0]; cyc(tag);
    endtask
    task automatic wr_ipi(int p, string tag);
        ipi_prio_wr = 1; ipi_prio_wdata = p[7:0]; cyc(tag);
    endtask
    task automatic do_ack(string tag);
        ack_rd = 1; cyc(tag);
    endtask
    task automatic do_eoi(int w, string tag);
        eoi_wr = 1; eoi_wdata = w; cyc(tag);
    endtask

    initial begin
        m_cur = 0; m_src = 0; m_pend = 'hFF; m_ipi = 'hFF; m_irq = 0;
        m_rej_v = 0; m_rej_src = 0; m_eoi_v = 0; m_eoi_src = 0; m_resend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        offer('h10, 4, "R3");         // current priority 0 refuses all
        wr_cur('hFF, "R8");           // nothing pending: resend, IPI off
        offer('h10, 4, "R4");
        offer('h20, 6, "R3");
        offer('h20, 4, "R3");         // equal to pending
        offer('h30, 2, "R4");         // displaces 0x10
        do_ack("R5");
        offer('h40, 1, "R4");
        wr_cur(3, "R8");              // higher, but something pending: no resend
        wr_cur(1, "R7");              // 1 <= pending 1: clear and reject 0x40
        offer('h41, 1, "R3");         // equal to current priority
        do_eoi('hFF000030, "R6");
        wr_ipi(8, "R9");
        chk(ack_rdata[23:0] == 24'(IPI), "R12", "ipi_src", ack_rdata[23:0], IPI);
        offer('h50, 9, "R3");
        wr_ipi(3, "R9");              // displaces IPI at priority 8
        wr_ipi(6, "R9");              // pending priority 3 already better
        do_ack("R5");
        do_eoi('hFF000005, "R10");    // resend re-presents the IPI
        wr_cur('h07, "R7");           // pending 6 is better than 7: kept
        do_ack("R5");
        wr_ipi('hFF, "R9");
        do_eoi('h40000005, "R6");
        eoi_wr = 1; eoi_wdata = 'hFF000011; offer_valid = 1; offer_src = 'h60; offer_prio = 1;
        cyc("R11");                   // offer loses to the EOI write
        offer(0, 1, "R11");           // source 0 ignored
        offer('h60, 1, "R4");
        // seeded mixed traffic, including simultaneous strobes
        begin
            int unsigned lfsr = 32'h1ACE_5EED;
            for (int i = 0; i < 600; i++) begin
                lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
                eoi_wr         = (lfsr[3:0] == 0);
                eoi_wdata      = {lfsr[11:4] | 8'h10, 16'h0, lfsr[23:16]};
                cur_prio_wr    = (lfsr[7:4] == 1);
                cur_prio_wdata = lfsr[15:8];
                ipi_prio_wr    = (lfsr[11:8] == 2);
                ipi_prio_wdata = lfsr[19:12];
                ack_rd         = (lfsr[15:12] == 3);
                offer_valid    = lfsr[16] | lfsr[17];
                offer_src      = {16'h0, lfsr[31:24]};
                offer_prio     = lfsr[27:20];
                cyc("R11");
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule